// File: doc/BRIEF.md
# Paging fault status and trap controller

This block gathers every exceptional condition raised by a paging unit and its neighbours (page-table fetches that hit absent memory, protection violations, an address-match breakpoint, single-instruction stepping and a time-slice counter) into one sticky status vector. From those conditions it drives a memory-protect flag and a level interrupt request. For the conditions that must stop the program before it moves on, it also raises a trap mode.

Trap mode changes when a pending interrupt may be taken. Normally the processor samples interrupts after the instruction fetch. In trap mode it samples them at the instruction boundary, so that no further fetch can fault again or overwrite the saved program counter. The block contains the 18-bit time-slice counter and the single-step flag. The processor datapath stays outside.

A software clear of the protect flag is the only way out of trap mode. A separate clear strobe empties the status vector. A per-reference inhibit input lets a faulting access record its cause without raising an interrupt.

Top module: `fst_ctrl`

## Requirements
- R1: After reset, the status vector, protect flag, trap mode, interrupt request, single-step flag, zero-data strobe and time-slice count are all zero.
- R2: A protection fault (descriptor length exceeded, write to read-only, write to read/write/first, no access, impure fetch) with inhibit low sets, on the next cycle, its cause bit (3, 4, 5, 7, 6 respectively), the fault bit (bit 1), the protect flag and trap mode.
- R3: With inhibit high, a protection fault sets only its cause bit. The fault bit, protect flag and trap mode are left as they were.
- R4: A page-table nonexistent-memory pulse sets status bit 2 and the protect flag, but neither the fault bit nor trap mode. If a read is pending in the same cycle, the zero-data strobe is high on the next cycle.
- R5: An instruction fetch while pure mode is on, from a page that is not read-only, is an impure-fetch fault (bit 6) handled as in R2 and R3. The same fetch from a read-only page, or with pure mode off, has no effect.
- R6: An address-match pulse sets status bit 8, the protect flag and trap mode, and does not set the fault bit.
- R7: The single-step flag is set by a load strobe and cleared by a PC-advance pulse. A PC-advance while the flag is set also sets status bit 0, the protect flag and trap mode. Without a PC-advance the flag holds.
- R8: The time-slice counter increments on a 1 MHz tick only when no interrupt is in progress, the interrupt system is on, and status bit 9 is clear. A load strobe overrides counting.
- R9: A counted tick at the all-ones value wraps the counter to zero and sets status bit 9 and the protect flag, without trap mode. The counter then holds until bit 9 is cleared.
- R10: The interrupt request equals the protect flag. The protect flag and trap mode hold until the software protect clear, and a new setting condition in the same cycle wins over the clear.
- R11: Status bits hold until the status clear strobe, and a bit being set in the same cycle as the clear ends up set.
- R12: The interrupt-take output is high when the interrupt request is high and either trap mode is on with the instruction-start strobe, or trap mode is off with the fetch-done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_pgnxm | input | 1 | Page-table fetch hit nonexistent memory |
| flt_dbl | input | 1 | Descriptor length exceeded |
| flt_wro | input | 1 | Write attempted to read-only page |
| flt_wrf | input | 1 | Write to read/write/first page |
| flt_noacc | input | 1 | No-access page referenced |
| ifetch | input | 1 | Current reference is an instruction fetch |
| pure_mode | input | 1 | Pure-procedure mode on |
| page_ro | input | 1 | Referenced page is read-only |
| addr_match | input | 1 | Address-match breakpoint hit |
| inhibit | input | 1 | Record fault cause without interrupt |
| rd_pend | input | 1 | A read is pending on the reference |
| step_load | input | 1 | Set the single-step flag |
| pc_adv | input | 1 | Instruction advanced the PC or transferred |
| instr_start | input | 1 | Instruction boundary strobe |
| fetch_done | input | 1 | Instruction fetch completed strobe |
| pi_active | input | 1 | Interrupt in progress |
| pi_on | input | 1 | Interrupt system enabled |
| tick_1us | input | 1 | 1 MHz tick |
| qt_load | input | 1 | Load the time-slice counter |
| qt_load_val | input | 18 | Value for the load |
| clr_prot | input | 1 | Software clear of protect flag and trap mode |
| clr_status | input | 1 | Software clear of the status vector |
| status | output | 10 | Sticky status bits |
| prot_flag | output | 1 | Memory-protect flag |
| irq | output | 1 | Interrupt request level |
| trap_mode | output | 1 | Sample interrupts at the instruction boundary |
| irq_take | output | 1 | Interrupt taken at this sampling point |
| step_flag | output | 1 | Single-step flag |
| qt_count | output | 18 | Time-slice count |
| rd_zero | output | 1 | Pending read completes with zero data |

## Verification
Sparse random pulses on every cause line, mixed with random inhibit, clears and ticks, separate the abort class from the breakpoint, step, page-NXM and overflow classes. Each class has its own fault-bit and trap-mode signature. Clears that arrive in the same cycle as new events show whether set wins over clear. Counter loads near the all-ones value, together with random interrupt-in-progress and system-off levels, show which ticks count, where the wrap happens and that the counter then stops. Directed cases cover inhibited faults, read-only versus impure fetches, and the two interrupt sampling points.

// File: rtl/fst_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the fault status and trap controller.
// Assumes a ten-bit status vector; bit positions are fixed because
// software decodes them.
package fst_pkg;
    localparam int ST_W     = 10;
    localparam int B_STEP   = 0;
    localparam int B_FAULT  = 1;
    localparam int B_PGNXM  = 2;
    localparam int B_DBL    = 3;
    localparam int B_WRO    = 4;
    localparam int B_WRF    = 5;
    localparam int B_IMPURE = 6;
    localparam int B_NOACC  = 7;
    localparam int B_MATCH  = 8;
    localparam int B_QOVF   = 9;
    localparam int N_ABORT  = 5;

    // Set requests produced each cycle by the cause decoder
    typedef struct packed {
        logic [ST_W-1:0] set_mask;
        logic            prot_set;
        logic            trap_set;
    } fst_evt_t;
endpackage

// File: rtl/fst_cause_decode.sv
`timescale 1ns/1ps
// Turns the per-cause pulses into set requests for the status vector,
// the protect flag and trap mode. Purely combinational.
// Assumes all cause inputs are single-cycle pulses aligned to clk.
module fst_cause_decode
    import fst_pkg::*;
(
    input  logic     flt_pgnxm,
    input  logic     flt_dbl,
    input  logic     flt_wro,
    input  logic     flt_wrf,
    input  logic     flt_noacc,
    input  logic     ifetch,
    input  logic     pure_mode,
    input  logic     page_ro,
    input  logic     addr_match,
    input  logic     step_evt,
    input  logic     qt_ovf,
    input  logic     inhibit,
    output fst_evt_t evt
);
    localparam int ABORT_POS [N_ABORT] = '{B_DBL, B_WRO, B_WRF, B_IMPURE, B_NOACC};

    logic               impure_fetch;
    logic [N_ABORT-1:0] abort_vec;
    logic               abort_any;
    logic               abort_live;

    // Impure fetch: pure code fetching from a writable page
    always_comb impure_fetch = ifetch & pure_mode & ~page_ro;

    // Group the aborting causes, ordered like ABORT_POS
    always_comb begin
        abort_vec  = {flt_noacc, impure_fetch, flt_wrf, flt_wro, flt_dbl};
        abort_any  = |abort_vec;
        abort_live = abort_any & ~inhibit;
    end

    // Assemble the set mask and the flag/trap set requests
    always_comb begin
        evt.set_mask = '0;
        for (int k = 0; k < N_ABORT; k++) begin
            evt.set_mask[ABORT_POS[k]] = abort_vec[k];
        end
        evt.set_mask[B_FAULT] = abort_live;
        evt.set_mask[B_PGNXM] = flt_pgnxm;
        evt.set_mask[B_STEP]  = step_evt;
        evt.set_mask[B_MATCH] = addr_match;
        evt.set_mask[B_QOVF]  = qt_ovf;
        evt.prot_set = abort_live | flt_pgnxm | addr_match | step_evt | qt_ovf;
        evt.trap_set = abort_live | addr_match | step_evt;
    end
endmodule

// File: rtl/fst_quantum.sv
`timescale 1ns/1ps
// Time-slice counter. Counts enabled 1 MHz ticks and flags the
// overflow on the tick that wraps it from all ones to zero. It holds while
// the overflow status bit is set. A load has priority over counting.
module fst_quantum #(
    parameter int QT_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_1us,
    input  logic            pi_active,
    input  logic            pi_on,
    input  logic            halted,
    input  logic            load,
    input  logic [QT_W-1:0] load_val,
    output logic [QT_W-1:0] count,
    output logic            ovf
);
    localparam logic [QT_W-1:0] QT_MAX = {QT_W{1'b1}};

    logic count_en;

    // Counting is allowed only outside interrupt service and while not halted
    always_comb begin
        count_en = tick_1us & ~pi_active & pi_on & ~halted;
        ovf      = count_en & (count == QT_MAX);
    end

    // Counter register with load priority
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (load)     count <= load_val;
        else if (count_en) count <= count + 1'b1;
    end
endmodule

// File: rtl/fst_step.sv
`timescale 1ns/1ps
// Single-step flag. A load sets it. An instruction that advances the PC
// clears it and, if it was set, reports a step event in that cycle.
// Assumes pc_adv pulses once per completed instruction.
module fst_step (
    input  logic clk,
    input  logic rst_n,
    input  logic step_load,
    input  logic pc_adv,
    output logic step_flag,
    output logic step_evt
);
    // Step event fires on the advance that consumes the flag
    always_comb step_evt = pc_adv & step_flag;

    // Flag register: load wins over the clearing advance
    always_ff @(posedge clk) begin
        if (!rst_n)         step_flag <= 1'b0;
        else if (step_load) step_flag <= 1'b1;
        else if (pc_adv)    step_flag <= 1'b0;
    end
endmodule

// File: rtl/fst_status_reg.sv
`timescale 1ns/1ps
// Sticky status vector plus protect flag and trap mode. Each bit is set
// by its request and cleared only by its software strobe; a set in the
// same cycle as a clear wins.
module fst_status_reg
    import fst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  fst_evt_t        evt,
    input  logic            clr_status,
    input  logic            clr_prot,
    output logic [ST_W-1:0] status,
    output logic            prot_flag,
    output logic            trap_mode
);
    // One sticky cell per status bit
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                  status[i] <= 1'b0;
            else if (evt.set_mask[i])    status[i] <= 1'b1;
            else if (clr_status)         status[i] <= 1'b0;
        end
    end

    // Protect flag: set by any interrupting event, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)            prot_flag <= 1'b0;
        else if (evt.prot_set) prot_flag <= 1'b1;
        else if (clr_prot)     prot_flag <= 1'b0;
    end

    // Trap mode: set by trapping events, leaves only with the protect clear
    always_ff @(posedge clk) begin
        if (!rst_n)            trap_mode <= 1'b0;
        else if (evt.trap_set) trap_mode <= 1'b1;
        else if (clr_prot)     trap_mode <= 1'b0;
    end
endmodule

// File: rtl/fst_ctrl.sv
`timescale 1ns/1ps
// Paging fault status and trap controller, top level. Wires the cause
// decoder, step flag, time-slice counter and status register. It also
// derives the interrupt request, the take strobe at the sampling point
// chosen by trap mode, and the zero-data strobe for reads that hit a
// missing page table.
module fst_ctrl
    import fst_pkg::*;
#(
    parameter int QT_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flt_pgnxm,
    input  logic            flt_dbl,
    input  logic            flt_wro,
    input  logic            flt_wrf,
    input  logic            flt_noacc,
    input  logic            ifetch,
    input  logic            pure_mode,
    input  logic            page_ro,
    input  logic            addr_match,
    input  logic            inhibit,
    input  logic            rd_pend,
    input  logic            step_load,
    input  logic            pc_adv,
    input  logic            instr_start,
    input  logic            fetch_done,
    input  logic            pi_active,
    input  logic            pi_on,
    input  logic            tick_1us,
    input  logic            qt_load,
    input  logic [QT_W-1:0] qt_load_val,
    input  logic            clr_prot,
    input  logic            clr_status,
    output logic [ST_W-1:0] status,
    output logic            prot_flag,
    output logic            irq,
    output logic            trap_mode,
    output logic            irq_take,
    output logic            step_flag,
    output logic [QT_W-1:0] qt_count,
    output logic            rd_zero
);
    fst_evt_t evt;
    logic     step_evt;
    logic     qt_ovf;

    fst_step u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_load (step_load),
        .pc_adv    (pc_adv),
        .step_flag (step_flag),
        .step_evt  (step_evt)
    );

    fst_quantum #(.QT_W(QT_W)) u_quantum (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1us  (tick_1us),
        .pi_active (pi_active),
        .pi_on     (pi_on),
        .halted    (status[B_QOVF]),
        .load      (qt_load),
        .load_val  (qt_load_val),
        .count     (qt_count),
        .ovf       (qt_ovf)
    );

    fst_cause_decode u_decode (
        .flt_pgnxm  (flt_pgnxm),
        .flt_dbl    (flt_dbl),
        .flt_wro    (flt_wro),
        .flt_wrf    (flt_wrf),
        .flt_noacc  (flt_noacc),
        .ifetch     (ifetch),
        .pure_mode  (pure_mode),
        .page_ro    (page_ro),
        .addr_match (addr_match),
        .step_evt   (step_evt),
        .qt_ovf     (qt_ovf),
        .inhibit    (inhibit),
        .evt        (evt)
    );

    fst_status_reg u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .clr_status (clr_status),
        .clr_prot   (clr_prot),
        .status     (status),
        .prot_flag  (prot_flag),
        .trap_mode  (trap_mode)
    );

    // Request level and the take strobe at the active sampling point
    always_comb begin
        irq      = prot_flag;
        irq_take = irq & (trap_mode ? instr_start : fetch_done);
    end

    // Zero-data strobe for a read whose page-table fetch found no memory
    always_ff @(posedge clk) begin
        if (!rst_n) rd_zero <= 1'b0;
        else        rd_zero <= flt_pgnxm & rd_pend;
    end
endmodule

// File: rtl/fst_ctrl_chk.sv
`timescale 1ns/1ps
// Temporal checks on the controller, attached to every instance by bind.
module fst_ctrl_chk
    import fst_pkg::*;
#(
    parameter int QT_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flt_wro,
    input logic            flt_pgnxm,
    input logic            inhibit,
    input logic            rd_pend,
    input logic            step_load,
    input logic            pc_adv,
    input logic            qt_load,
    input logic            clr_prot,
    input logic            clr_status,
    input logic [ST_W-1:0] status,
    input logic            prot_flag,
    input logic            trap_mode,
    input logic            step_flag,
    input logic [QT_W-1:0] qt_count,
    input logic            rd_zero
);
    AST_FAULT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_wro && !inhibit) |=> (trap_mode && prot_flag && status[B_FAULT])); // R2
    AST_FAULT_BIT_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_FAULT]) |-> $past(!inhibit)); // R3
    AST_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_pgnxm && rd_pend) |=> rd_zero); // R4
    AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_adv && !step_load) |=> !step_flag); // R7
    AST_QT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_QOVF] && !qt_load) |=> $stable(qt_count)); // R9
    AST_TRAP_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_mode |-> prot_flag); // R10
    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_mode && !clr_prot) |=> trap_mode); // R10
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_status |=> ((status & $past(status)) == $past(status))); // R11
endmodule

bind fst_ctrl fst_ctrl_chk #(.QT_W(QT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_wro    (flt_wro),
    .flt_pgnxm  (flt_pgnxm),
    .inhibit    (inhibit),
    .rd_pend    (rd_pend),
    .step_load  (step_load),
    .pc_adv     (pc_adv),
    .qt_load    (qt_load),
    .clr_prot   (clr_prot),
    .clr_status (clr_status),
    .status     (status),
    .prot_flag  (prot_flag),
    .trap_mode  (trap_mode),
    .step_flag  (step_flag),
    .qt_count   (qt_count),
    .rd_zero    (rd_zero)
);

// File: tb/fst_ctrl_test.sv
`timescale 1ns/1ps
module fst_ctrl_test;
    localparam int QW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flt_pgnxm, flt_dbl, flt_wro, flt_wrf, flt_noacc;
    logic ifetch, pure_mode, page_ro, addr_match, inhibit, rd_pend;
    logic step_load, pc_adv, instr_start, fetch_done;
    logic pi_active, pi_on, tick_1us, qt_load, clr_prot, clr_status;
    logic [QW-1:0] qt_load_val;
    logic [9:0]    status;
    logic          prot_flag, irq, trap_mode, irq_take, step_flag, rd_zero;
    logic [QW-1:0] qt_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expected state
    logic [9:0]    m_st;
    logic          m_prot, m_trap, m_step, m_rdz;
    logic [QW-1:0] m_qt;

    always #2.5 clk = ~clk;

    fst_ctrl uut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {flt_pgnxm, flt_dbl, flt_wro, flt_wrf, flt_noacc} = '0;
        {ifetch, pure_mode, page_ro, addr_match, inhibit, rd_pend} = '0;
        {step_load, pc_adv, instr_start, fetch_done} = '0;
        {pi_active, tick_1us, qt_load, clr_prot, clr_status} = '0;
        pi_on = 1'b1;
        qt_load_val = '0;
    endtask

    // Expected next status mask from the requirement text (R2..R9)
    function automatic logic [9:0] exp_mask(input logic sevt, input logic ovf);
        logic imp, ab;
        logic [9:0] m;
        imp = ifetch & pure_mode & ~page_ro;            // R5
        ab  = flt_dbl | flt_wro | flt_wrf | flt_noacc | imp;
        m = '0;
        m[3] = flt_dbl; m[4] = flt_wro; m[5] = flt_wrf; m[6] = imp; m[7] = flt_noacc;
        m[1] = ab & ~inhibit;                           // R2 R3
        m[2] = flt_pgnxm;                               // R4
        m[0] = sevt;                                    // R7
        m[8] = addr_match;                              // R6
        m[9] = ovf;                                     // R9
        return m;
    endfunction

    // Check registered outputs against the model (at negedge)
    task automatic check_state();
        chk("R11", "status", 32'(status), 32'(m_st));
        chk("R10", "prot_flag", 32'(prot_flag), 32'(m_prot));
        chk("R10", "irq", 32'(irq), 32'(m_prot));
        chk("R2", "trap_mode", 32'(trap_mode), 32'(m_trap));
        chk("R7", "step_flag", 32'(step_flag), 32'(m_step));
        chk("R8", "qt_count", 32'(qt_count), 32'(m_qt));
        chk("R4", "rd_zero", 32'(rd_zero), 32'(m_rdz));
    endtask

    // Inputs already driven: check take strobe, clock, advance model
    task automatic cycle();
        logic sevt, en, ovf, ab_live, imp;
        logic [9:0] msk;
        #1;
        chk("R12", "irq_take", 32'(irq_take),
            32'(m_prot & (m_trap ? instr_start : fetch_done)));
        imp  = ifetch & pure_mode & ~page_ro;
        sevt = pc_adv & m_step;
        en   = tick_1us & ~pi_active & pi_on & ~m_st[9];
        ovf  = en & (m_qt == {QW{1'b1}});
        msk  = exp_mask(sevt, ovf);
        ab_live = (flt_dbl | flt_wro | flt_wrf | flt_noacc | imp) & ~inhibit;
        m_st   = msk | (clr_status ? 10'b0 : m_st);
        m_prot = (ab_live | flt_pgnxm | addr_match | sevt | ovf) | (clr_prot ? 1'b0 : m_prot);
        m_trap = (ab_live | addr_match | sevt) | (clr_prot ? 1'b0 : m_trap);
        m_step = step_load | (pc_adv ? 1'b0 : m_step);
        m_qt   = qt_load ? qt_load_val : (en ? m_qt + 1'b1 : m_qt);
        m_rdz  = flt_pgnxm & rd_pend;
        @(negedge clk);
        check_state();
        idle_inputs();
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4411));
        idle_inputs();
        m_st = '0; m_prot = 0; m_trap = 0; m_step = 0; m_rdz = 0; m_qt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "status", 32'(status), 0);
        chk("R1", "prot/trap/irq", 32'({prot_flag, trap_mode, irq}), 0);
        chk("R1", "step/rdz/qt", 32'({step_flag, rd_zero, qt_count}), 0);

        // R3: inhibited fault records cause only
        inhibit = 1; flt_wro = 1; cycle();
        chk("R3", "wro bit alone", 32'(status), 32'h010);
        chk("R3", "no prot", 32'(prot_flag), 0);
        // R5: fetch from read-only page in pure mode is harmless
        ifetch = 1; pure_mode = 1; page_ro = 1; cycle();
        chk("R5", "ro fetch no bit6", 32'(status[6]), 0);
        // R5: impure fetch is a fault
        ifetch = 1; pure_mode = 1; cycle();
        chk("R5", "impure fault", 32'({status[6], status[1], trap_mode}), 32'h7);
        // R12: trap mode samples at instruction start, not fetch done
        fetch_done = 1; cycle();
        instr_start = 1; cycle();
        // R10: clear races with new match -> set wins
        clr_prot = 1; addr_match = 1; cycle();
        chk("R10", "set beats clear", 32'({prot_flag, trap_mode}), 32'h3);
        clr_prot = 1; clr_status = 1; cycle();
        chk("R11", "clear", 32'(status), 0);
        // R12: normal mode samples after fetch
        flt_pgnxm = 1; rd_pend = 1; cycle();
        chk("R4", "nxm no trap", 32'({prot_flag, trap_mode, status[1]}), 32'h4);
        fetch_done = 1; cycle();
        clr_prot = 1; clr_status = 1; cycle();
        // R7: step flag kept without advance, consumed by advance
        step_load = 1; cycle();
        cycle();
        pc_adv = 1; cycle();
        chk("R7", "step event", 32'({status[0], step_flag, trap_mode}), 32'h5);
        clr_prot = 1; clr_status = 1; cycle();
        // R9: overflow wraps, sets bit 9 without trap, then halts
        qt_load = 1; qt_load_val = {QW{1'b1}} - 18'd1; cycle();
        for (int i = 0; i < 4; i++) begin tick_1us = 1; cycle(); end
        chk("R9", "halted at zero", 32'({status[9], trap_mode, qt_count}), 32'({1'b1, 1'b0, 18'd0}));
        clr_status = 1; clr_prot = 1; cycle();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            flt_pgnxm  = ($urandom % 24) == 0;
            flt_dbl    = ($urandom % 32) == 0;
            flt_wro    = ($urandom % 32) == 0;
            flt_wrf    = ($urandom % 32) == 0;
            flt_noacc  = ($urandom % 32) == 0;
            ifetch     = ($urandom % 4) == 0;
            pure_mode  = ($urandom % 3) == 0;
            page_ro    = ($urandom % 2) == 0;
            addr_match = ($urandom % 40) == 0;
            inhibit    = ($urandom % 3) == 0;
            rd_pend    = ($urandom % 2) == 0;
            step_load  = ($urandom % 20) == 0;
            pc_adv     = ($urandom % 4) == 0;
            instr_start= ($urandom % 3) == 0;
            fetch_done = ($urandom % 3) == 0;
            pi_active  = ($urandom % 8) == 0;
            pi_on      = ($urandom % 10) != 0;
            tick_1us   = ($urandom % 2) == 0;
            qt_load    = ($urandom % 64) == 0;
            qt_load_val= {QW{1'b1}} - QW'($urandom % 6);
            clr_prot   = ($urandom % 12) == 0;
            clr_status = ($urandom % 16) == 0;
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule